// File: doc/BRIEF.md
# Paged EEPROM Access Controller

This block places a 64-byte nonvolatile array at data-space offsets 00h to 3Fh. The processor reaches it with ordinary loads and stores on a small bus (address, write data, read data, read strobe, write strobe). A separate bank register drives the `bank_sel` input. An 8-bit control/status register sits on its own port. The block decides which accesses take effect and runs a timed programming cycle.

Programming has two modes. In byte mode one store programs one location. In parallel mode, stores to one aligned 8-byte row (row index = address bits 5:3) are gathered in a row latch with a valid flag per byte. A start command then programs all gathered bytes in a single cycle. The programming time is set by the parameter `PROG_CYCLES`, counted internally. The `busy` output is high for the whole cycle.

A three-state machine controls the block:
- **IDLE** leaves by *byte launch* (byte-mode store with enable set, to PROG) or by *first gather* (parallel-mode store, to GATHER).
- **GATHER** leaves by *row start* (to PROG) or by *abandon*, when a control write clears the parallel-mode bit (to IDLE).
- **PROG** leaves by *cycle done*, when the counter expires (to IDLE).

Top module: `eep_page_ctrl`

## Requirements
- R1: When `bank_sel`=1, the off bit is 0 and `busy`=0, a read strobe returns the addressed byte on `bus_rdata` one clock later.
- R2: A read strobe while `bank_sel`=0, the off bit is 1 or `busy`=1 yields `bus_rdata`=00h one clock later.
- R3: A store while `bank_sel`=0, the off bit is 1 or `busy`=1 leaves the array unchanged and starts no program cycle.
- R4: In byte mode (control bit 3 = 0), a store with the enable bit (control bit 0) set programs that one location. With the enable bit clear, the store is dropped and `busy` stays low.
- R5: `busy` rises on the clock after the triggering write and stays high for exactly `PROG_CYCLES` clocks.
- R6: While `busy`=1, control writes are ignored and `ctl_rdata` reads 02h, which shows only the busy bit.
- R7: Control layout: bit 0 enable, bit 1 busy (read-only), bit 2 off, bit 3 parallel mode, bit 6 start (self-clearing, reads 0). Bits 4, 5 and 7 always read 0. The reset value is 04h.
- R8: In parallel mode, each store is held in the row latch and the array is not changed. The first store fixes the row. A later store to a different row is ignored.
- R9: A control write with start, enable and parallel mode all set, while bytes are gathered, programs only the gathered bytes in one cycle and then empties the latch. A start without the enable bit has no effect.
- R10: A control write that clears the parallel-mode bit while bytes are gathered discards them. The next parallel store may then fix a new row.
- R11: After reset, every array location reads FFh (the erased value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Array offset |
| bus_wdata | input | 8 | Store data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, registered |
| bank_sel | input | 1 | Array bank selected by the bank register |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control/status readback |
| busy | output | 1 | Program cycle in progress |

## Verification
A vector table drives single byte-mode stores under every gating pattern: bank unselected, block off, enable clear, and the fully enabled case at the first, a middle and the last offset. Reading back afterwards separates a dropped store (FFh stays) from a programmed one. Directed sequences follow. They overlap reads, stores and control writes with a running cycle, which separates the busy lock from ordinary gating. They also gather a sparse row with one store from another row, to show that only the valid lanes of the fixed row are programmed. Finally they issue a start without enable and then abandon the gather, to show that the latch is kept in the first case and emptied in the second.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_PROG   = 2'd2
    } eep_state_e;

    localparam int CTL_W     = 8;
    localparam int CTL_EN    = 0;
    localparam int CTL_BUSY  = 1;
    localparam int CTL_OFF   = 2;
    localparam int CTL_PMODE = 3;
    localparam int CTL_START = 6;
endpackage

// File: rtl/eep_ctl_reg.sv
module eep_ctl_reg
    import eep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_take,
    input  logic [CTL_W-1:0] wdata,
    input  logic             busy,
    output logic             en_q,
    output logic             off_q,
    output logic             pmode_q,
    output logic [CTL_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            off_q   <= 1'b1;
            pmode_q <= 1'b0;
        end else if (wr_take) begin
            en_q    <= wdata[CTL_EN];
            off_q   <= wdata[CTL_OFF];
            pmode_q <= wdata[CTL_PMODE];
        end
    end

    // While a cycle runs only the busy flag is visible.
    always_comb begin
        rdata = '0;
        if (busy) begin
            rdata[CTL_BUSY] = 1'b1;
        end else begin
            rdata[CTL_EN]    = en_q;
            rdata[CTL_OFF]   = off_q;
            rdata[CTL_PMODE] = pmode_q;
        end
    end
endmodule

// File: rtl/eep_row_latch.sv
module eep_row_latch #(
    parameter int DATA_W    = 8,
    parameter int ROW_BYTES = 8,
    parameter int ROW_W     = 3,
    localparam int LANE_W   = $clog2(ROW_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               load,
    input  logic [ROW_W-1:0]                   load_row,
    input  logic [LANE_W-1:0]                  load_lane,
    input  logic [DATA_W-1:0]                  load_data,
    output logic [ROW_W-1:0]                   row_q,
    output logic [ROW_BYTES-1:0][DATA_W-1:0]   data_q,
    output logic [ROW_BYTES-1:0]               valid_q,
    output logic                               has_data
);
    logic accept;

    assign has_data = |valid_q;
    assign accept   = load && !clr && (!has_data || (load_row == row_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (accept && !has_data) begin
            row_q <= load_row;
        end
    end

    for (genvar l = 0; l < ROW_BYTES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[l] <= 1'b0;
                data_q[l]  <= '0;
            end else if (clr) begin
                valid_q[l] <= 1'b0;
            end else if (accept && (load_lane == LANE_W'(l))) begin
                valid_q[l] <= 1'b1;
                data_q[l]  <= load_data;
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                ROW_BYTES = 8,
    parameter logic [DATA_W-1:0] ERASED    = '1,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int LANE_W = $clog2(ROW_BYTES),
    localparam int ROW_W  = ADDR_W - LANE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  logic [ROW_W-1:0]                 commit_row,
    input  logic [ROW_BYTES-1:0][DATA_W-1:0] commit_data,
    input  logic [ROW_BYTES-1:0]             commit_valid,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int ROW  = g / ROW_BYTES;
        localparam int LANE = g % ROW_BYTES;
        logic [DATA_W-1:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= ERASED;
            end else if (commit && (commit_row == ROW_W'(ROW)) && commit_valid[LANE]) begin
                cell_q <= commit_data[LANE];
            end
        end
        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                DATA_W      = 8,
    parameter int                ROW_BYTES   = 8,
    parameter int                PROG_CYCLES = 16,
    parameter logic [DATA_W-1:0] ERASED      = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bank_sel,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              busy
);
    localparam int LANE_W = $clog2(ROW_BYTES);
    localparam int ROW_W  = ADDR_W - LANE_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

    eep_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    logic en_q, off_q, pmode_q;
    logic access_ok, rd_ok, wr_ok, ctl_take;
    logic byte_go, par_store, start_go, abandon, cnt_done, commit;
    logic latch_load, latch_clr;
    logic [ROW_W-1:0]                 addr_row, row_q;
    logic [LANE_W-1:0]                addr_lane;
    logic [ROW_BYTES-1:0][DATA_W-1:0] row_data;
    logic [ROW_BYTES-1:0]             row_valid;
    logic                             row_has;
    logic [DATA_W-1:0]                arr_rd;

    assign busy      = (state_q == ST_PROG);
    assign access_ok = bank_sel && !off_q && !busy;
    assign rd_ok     = bus_rd && access_ok;
    assign wr_ok     = bus_wr && access_ok;
    assign ctl_take  = ctl_wr && !busy;
    assign addr_row  = bus_addr[ADDR_W-1:LANE_W];
    assign addr_lane = bus_addr[LANE_W-1:0];
    assign cnt_done  = (cnt_q == '0);

    // Named transition conditions
    assign byte_go   = wr_ok && !pmode_q && en_q && (state_q == ST_IDLE);
    assign par_store = wr_ok && pmode_q && (state_q != ST_PROG);
    assign start_go  = ctl_take && (state_q == ST_GATHER) && row_has
                       && ctl_wdata[CTL_START] && ctl_wdata[CTL_EN] && ctl_wdata[CTL_PMODE];
    assign abandon   = ctl_take && (state_q == ST_GATHER) && !ctl_wdata[CTL_PMODE];
    assign commit    = busy && cnt_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_go)        state_d = ST_PROG;    // byte launch
                else if (par_store) state_d = ST_GATHER;  // first gather
            end
            ST_GATHER: begin
                if (abandon)        state_d = ST_IDLE;    // abandon
                else if (start_go)  state_d = ST_PROG;    // row start
            end
            ST_PROG: begin
                if (cnt_done)       state_d = ST_IDLE;    // cycle done
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        latch_load = byte_go || par_store;
        latch_clr  = commit || abandon;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if ((state_d == ST_PROG) && (state_q != ST_PROG)) begin
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy && !cnt_done) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_ok ? arr_rd : '0;
        end
    end

    eep_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_take (ctl_take),
        .wdata   (ctl_wdata),
        .busy    (busy),
        .en_q    (en_q),
        .off_q   (off_q),
        .pmode_q (pmode_q),
        .rdata   (ctl_rdata)
    );

    eep_row_latch #(
        .DATA_W    (DATA_W),
        .ROW_BYTES (ROW_BYTES),
        .ROW_W     (ROW_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (latch_clr),
        .load      (latch_load),
        .load_row  (addr_row),
        .load_lane (addr_lane),
        .load_data (bus_wdata),
        .row_q     (row_q),
        .data_q    (row_data),
        .valid_q   (row_valid),
        .has_data  (row_has)
    );

    eep_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ROW_BYTES (ROW_BYTES),
        .ERASED    (ERASED)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_row   (row_q),
        .commit_data  (row_data),
        .commit_valid (row_valid),
        .rd_addr      (bus_addr),
        .rd_data      (arr_rd)
    );
endmodule

// File: rtl/eep_page_checker.sv
module eep_page_checker #(
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bank_sel,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ctl_wr,
    input logic [7:0]        ctl_rdata,
    input logic              busy
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_gated_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && (!bank_sel || busy)) |-> (bus_rdata == '0));

    assert_busy_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr || ctl_wr));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == PROG_CYCLES));

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < PROG_CYCLES));

    assert_ctl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_rdata == 8'h02));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:4] == 4'h0);
endmodule

bind eep_page_ctrl eep_page_checker #(
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bank_sel  (bank_sel),
    .bus_rdata (bus_rdata),
    .ctl_wr    (ctl_wr),
    .ctl_rdata (ctl_rdata),
    .busy      (busy)
);

// File: tb/eep_page_ctrl_bench.sv
module eep_page_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int PC    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, bank_sel = 1'b0, ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] bus_rdata, ctl_rdata;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    eep_page_ctrl #(.PROG_CYCLES(PC)) u_eep_page_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bank_sel(bank_sel),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .busy(busy)
    );

    typedef struct packed {
        logic       bank;
        logic       off;
        logic       en;
        logic [5:0] addr;
        logic [7:0] data;
        logic       busy_exp;
        logic [7:0] exp;
    } vec_t;

    // Byte-mode stores under each gating pattern (R3, R4, R1)
    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b1, 6'h05, 8'hA5, 1'b1, 8'hA5},
        '{1'b0, 1'b0, 1'b1, 6'h06, 8'h3C, 1'b0, 8'hFF},
        '{1'b1, 1'b1, 1'b1, 6'h07, 8'h5A, 1'b0, 8'hFF},
        '{1'b1, 1'b0, 1'b0, 6'h08, 8'h11, 1'b0, 8'hFF},
        '{1'b1, 1'b0, 1'b1, 6'h3F, 8'h7E, 1'b1, 8'h7E},
        '{1'b1, 1'b0, 1'b1, 6'h00, 8'h81, 1'b1, 8'h81}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R7 reset ctl", ctl_rdata, 8'h04);
        chk("R5 reset busy", {7'b0, busy}, 8'h00);
        chk("R2 reset rdata", bus_rdata, 8'h00);
        bank_sel = 1'b1;
        bus_read(6'h05, rd);
        chk("R2 read while off", rd, 8'h00);
        ctl_write(8'h00);
        bus_read(6'h05, rd);
        chk("R11 erased after reset", rd, 8'hFF);

        // Vector table
        foreach (VECS[i]) begin
            bank_sel = VECS[i].bank;
            ctl_write({5'b0, VECS[i].off, 1'b0, VECS[i].en});
            bus_write(VECS[i].addr, VECS[i].data);
            chk($sformatf("R4/R3 busy vec%0d", i), {7'b0, busy}, {7'b0, VECS[i].busy_exp});
            wait_idle();
            bank_sel = 1'b1;
            ctl_write(8'h00);
            bus_read(VECS[i].addr, rd);
            chk($sformatf("R1/R4 readback vec%0d", i), rd, VECS[i].exp);
        end

        // Busy length
        ctl_write(8'h01);
        bus_write(6'h10, 8'h42);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R5 busy length", 8'(n), 8'(PC));

        // Activity during a running cycle
        bus_write(6'h11, 8'h43);
        ctl_write(8'h0D);
        chk("R6 ctl while busy", ctl_rdata, 8'h02);
        bus_read(6'h11, rd);
        chk("R2 read while busy", rd, 8'h00);
        bus_write(6'h12, 8'h99);
        wait_idle();
        @(negedge clk);
        chk("R6 ctl write ignored", ctl_rdata, 8'h01);
        chk("R3 no cycle from busy store", {7'b0, busy}, 8'h00);
        bus_read(6'h11, rd);
        chk("R4 programmed", rd, 8'h43);
        bus_read(6'h12, rd);
        chk("R3 busy store dropped", rd, 8'hFF);

        // Reserved and self-clearing bits
        ctl_write(8'hF1);
        chk("R7 reserved masked", ctl_rdata, 8'h01);

        // Parallel gather
        ctl_write(8'h09);
        bus_write(6'h30, 8'h11);
        bus_write(6'h32, 8'h22);
        bus_write(6'h37, 8'h77);
        bus_write(6'h38, 8'h88);
        chk("R8 no cycle on gather", {7'b0, busy}, 8'h00);
        bus_read(6'h30, rd);
        chk("R8 array untouched", rd, 8'hFF);
        ctl_write(8'h49);
        chk("R9 start raises busy", {7'b0, busy}, 8'h01);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R9 one cycle for row", 8'(n), 8'(PC));
        chk("R7 start self-clears", ctl_rdata, 8'h09);
        bus_read(6'h30, rd); chk("R9 lane0", rd, 8'h11);
        bus_read(6'h31, rd); chk("R9 lane1 untouched", rd, 8'hFF);
        bus_read(6'h32, rd); chk("R9 lane2", rd, 8'h22);
        bus_read(6'h37, rd); chk("R9 lane7", rd, 8'h77);
        bus_read(6'h38, rd); chk("R8 other row ignored", rd, 8'hFF);

        // Start without enable, then abandon
        ctl_write(8'h08);
        bus_write(6'h20, 8'h55);
        ctl_write(8'h48);
        chk("R9 start without enable", {7'b0, busy}, 8'h00);
        bus_read(6'h20, rd);
        chk("R9 no program without enable", rd, 8'hFF);
        ctl_write(8'h00);
        ctl_write(8'h09);
        bus_write(6'h28, 8'h66);
        ctl_write(8'h49);
        wait_idle();
        bus_read(6'h28, rd);
        chk("R10 new row after abandon", rd, 8'h66);
        bus_read(6'h20, rd);
        chk("R10 abandoned byte discarded", rd, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule